// File: doc/BRIEF.md
# Parity Error Observation Logger

This block watches the data parity error indication of a PCI/PCI-X segment and keeps a record of what it saw in two status bits. One bit, *observed*, records any parity error on the bus, whichever agent flagged it. The other bit, *dropped-post*, records a parity error on posted write data that this bridge drove itself and did not corrupt on purpose, provided the parity response enable is on. A parity error on posted data that the bridge poisoned deliberately sets only the observed bit.

The status bits stay set until software clears them with a write-one-to-clear strobe. A one-shot mode makes dropped-post a single-cycle pulse, so it never needs clearing. Each status bit is routed to three system error actions through its own mapping controls: a sync-flood request, a fatal interrupt request and a nonfatal interrupt request. The flood route of dropped-post is enabled by clearing an inhibit control. All three requests are level signals.

The parity indication is expected to be synchronized already. An event is taken on its rising edge, and the qualifiers are sampled in that same cycle.

Top module: `perr_logger`

## Requirements
- R1: While reset is asserted, both status bits and all three request outputs are 0.
- R2: A rising edge of `perr_in` sets `stat_obs` at the next clock edge, whatever the values of `own_drv`, `posted_op`, `poisoned` and `resp_en`.
- R3: A `perr_in` assertion held for several cycles logs only once. If `stat_obs` is cleared while `perr_in` stays high, it stays 0 until `perr_in` falls and rises again.
- R4: A rising edge of `perr_in` with `own_drv`, `posted_op` and `resp_en` at 1 and `poisoned` at 0 sets `stat_drop` at the next clock edge.
- R5: When `poisoned` is 1 at the event, `stat_drop` is not set. `stat_obs` is still set.
- R6: When `own_drv`, `posted_op` or `resp_en` is 0 at the event, `stat_drop` is not set.
- R7: With `clr_wr` high, bit 0 of `clr_mask` clears `stat_obs` and bit 1 clears `stat_drop`. A mask bit at 0 leaves its status bit unchanged. With `clr_wr` low, the mask has no effect.
- R8: A logging event in the same cycle as a clear of the same bit leaves the bit set.
- R9: With `one_shot` at 1, `stat_drop` is high for exactly one cycle after each qualifying event.
- R10: `flood_req` = (`stat_obs` AND `obs_flood_en`) OR (`stat_drop` AND NOT `drop_flood_inh`).
- R11: `fatal_req` = (`stat_obs` AND `obs_fatal_en`) OR (`stat_drop` AND `drop_fatal_en`). `nonfatal_req` is formed the same way from `obs_nonfatal_en` and `drop_nonfatal_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| perr_in | input | 1 | Synchronized parity error indication, active high |
| own_drv | input | 1 | The flagged data was driven by this bridge |
| posted_op | input | 1 | The flagged data belongs to a posted write |
| poisoned | input | 1 | The flagged data was poisoned on purpose |
| resp_en | input | 1 | Parity error response enable |
| one_shot | input | 1 | Dropped-post status is a one-cycle pulse |
| drop_flood_inh | input | 1 | Inhibits sync flood from dropped-post |
| drop_fatal_en | input | 1 | Dropped-post raises a fatal request |
| drop_nonfatal_en | input | 1 | Dropped-post raises a nonfatal request |
| obs_flood_en | input | 1 | Observed raises a sync flood request |
| obs_fatal_en | input | 1 | Observed raises a fatal request |
| obs_nonfatal_en | input | 1 | Observed raises a nonfatal request |
| clr_wr | input | 1 | Write strobe for the status clear |
| clr_mask | input | 2 | Write-one-to-clear mask: bit 0 observed, bit 1 dropped-post |
| stat_obs | output | 1 | Parity-error-observed status |
| stat_drop | output | 1 | Dropped-post status |
| flood_req | output | 1 | Sync flood request |
| fatal_req | output | 1 | Fatal interrupt request |
| nonfatal_req | output | 1 | Nonfatal interrupt request |

## Verification
The assertions check the properties that hold on every cycle. No two logging events occur back to back. Every event sets its bit on the next edge, even against a clear. A clear with no event empties the bit. A one-shot dropped-post bit never stays high for two cycles. The dropped-post bit rises only after a qualifying event. No request is raised while both status bits are clear. The bench scenarios cover what a single cycle cannot show: each qualifier combination and mapping choice checked against its expected outputs, a long assertion with a clear in the middle of it, a partial mask, a mask sent without its strobe, and an event that arrives together with a clear.

// File: rtl/perr_log_pkg.sv
package perr_log_pkg;

  // Status bit positions; the clear mask uses the same positions.
  localparam int OBS_IDX  = 0;
  localparam int DROP_IDX = 1;
  localparam int STAT_W   = 2;

  typedef logic [STAT_W-1:0] stat_vec_t;

  // A posted-write parity error is counted as dropped only for clean,
  // bridge-driven data with the response enable on.
  function automatic logic drop_qualifies(
    input logic own,
    input logic posted,
    input logic poison,
    input logic resp
  );
    return own & posted & ~poison & resp;
  endfunction

  // Route the two status bits onto one request line.
  function automatic logic route_req(
    input logic obs,
    input logic obs_en,
    input logic drop,
    input logic drop_en
  );
    return (obs & obs_en) | (drop & drop_en);
  endfunction

  // Next value of a status cell.
  function automatic logic cell_next(
    input logic cur,
    input logic set,
    input logic clr,
    input logic pulse
  );
    return set | (cur & ~clr & ~pulse);
  endfunction

endpackage

// File: rtl/perr_edge_qual.sv
module perr_edge_qual
  import perr_log_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic perr_in,
  input  logic own_drv,
  input  logic posted_op,
  input  logic poisoned,
  input  logic resp_en,
  output logic obs_evt,
  output logic drop_evt
);

  logic perr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) perr_q <= 1'b0;
    else        perr_q <= perr_in;
  end

  // Only a rising edge counts, so a long assertion logs once.
  assign obs_evt  = perr_in & ~perr_q;
  assign drop_evt = obs_evt & drop_qualifies(own_drv, posted_op, poisoned, resp_en);

  // R3
  no_repeat_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    obs_evt |=> !obs_evt);

  // R4
  drop_implies_obs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> obs_evt);

endmodule

// File: rtl/perr_stat_cell.sv
module perr_stat_cell
  import perr_log_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  input  logic pulse,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= cell_next(q, set_evt, clr, pulse);
  end

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> q);

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !q);

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && q) |=> !q);

endmodule

// File: rtl/perr_router.sv
module perr_router
  import perr_log_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  stat_vec_t stat,
  input  logic      drop_flood_inh,
  input  logic      drop_fatal_en,
  input  logic      drop_nonfatal_en,
  input  logic      obs_flood_en,
  input  logic      obs_fatal_en,
  input  logic      obs_nonfatal_en,
  output logic      flood_req,
  output logic      fatal_req,
  output logic      nonfatal_req
);

  assign flood_req    = route_req(stat[OBS_IDX], obs_flood_en,
                                  stat[DROP_IDX], ~drop_flood_inh);
  assign fatal_req    = route_req(stat[OBS_IDX], obs_fatal_en,
                                  stat[DROP_IDX], drop_fatal_en);
  assign nonfatal_req = route_req(stat[OBS_IDX], obs_nonfatal_en,
                                  stat[DROP_IDX], drop_nonfatal_en);

  // R10
  quiet_when_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0) |-> !(flood_req || fatal_req || nonfatal_req));

  // R11
  obs_fatal_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[OBS_IDX] && obs_fatal_en) |-> fatal_req);

endmodule

// File: rtl/perr_logger.sv
module perr_logger
  import perr_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              perr_in,
  input  logic              own_drv,
  input  logic              posted_op,
  input  logic              poisoned,
  input  logic              resp_en,
  input  logic              one_shot,
  input  logic              drop_flood_inh,
  input  logic              drop_fatal_en,
  input  logic              drop_nonfatal_en,
  input  logic              obs_flood_en,
  input  logic              obs_fatal_en,
  input  logic              obs_nonfatal_en,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_mask,
  output logic              stat_obs,
  output logic              stat_drop,
  output logic              flood_req,
  output logic              fatal_req,
  output logic              nonfatal_req
);

  logic      obs_evt, drop_evt;
  stat_vec_t set_vec, clr_vec, pulse_vec, stat;

  perr_edge_qual u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .perr_in   (perr_in),
    .own_drv   (own_drv),
    .posted_op (posted_op),
    .poisoned  (poisoned),
    .resp_en   (resp_en),
    .obs_evt   (obs_evt),
    .drop_evt  (drop_evt)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[OBS_IDX]  = obs_evt;
    set_vec[DROP_IDX] = drop_evt;
    pulse_vec           = '0;
    pulse_vec[DROP_IDX] = one_shot;
    clr_vec = clr_wr ? clr_mask : '0;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_cell
    perr_stat_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_vec[i]),
      .clr     (clr_vec[i]),
      .pulse   (pulse_vec[i]),
      .q       (stat[i])
    );
  end

  assign stat_obs  = stat[OBS_IDX];
  assign stat_drop = stat[DROP_IDX];

  perr_router u_route (
    .clk              (clk),
    .rst_n            (rst_n),
    .stat             (stat),
    .drop_flood_inh   (drop_flood_inh),
    .drop_fatal_en    (drop_fatal_en),
    .drop_nonfatal_en (drop_nonfatal_en),
    .obs_flood_en     (obs_flood_en),
    .obs_fatal_en     (obs_fatal_en),
    .obs_nonfatal_en  (obs_nonfatal_en),
    .flood_req        (flood_req),
    .fatal_req        (fatal_req),
    .nonfatal_req     (nonfatal_req)
  );

  // R2
  obs_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    obs_evt |=> stat_obs);

  // R5
  drop_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_drop) |-> $past(drop_evt));

endmodule

// File: tb/sim_perr_logger.sv
module sim_perr_logger;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic perr_in = 0, own_drv = 0, posted_op = 0, poisoned = 0, resp_en = 0;
  logic one_shot = 0, drop_flood_inh = 0, drop_fatal_en = 0, drop_nonfatal_en = 0;
  logic obs_flood_en = 0, obs_fatal_en = 0, obs_nonfatal_en = 0, clr_wr = 0;
  logic [1:0] clr_mask = 2'b00;
  logic stat_obs, stat_drop, flood_req, fatal_req, nonfatal_req;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  perr_logger u0 (.*);

  // [15]own [14]posted [13]poison [12]resp [11]one_shot [10]drop_flood_inh
  // [9]drop_fatal [8]drop_nonfatal [7]obs_flood [6]obs_fatal [5]obs_nonfatal
  // expected: [4]obs [3]drop [2]flood [1]fatal [0]nonfatal
  localparam logic [15:0] VEC [8] = '{
    16'b0101_0100_1001_0100, // R2 R6: not own, obs flood only
    16'b1101_0010_0001_1110, // R4 R10 R11: drop, flood via no inhibit, fatal
    16'b1111_0010_0011_0001, // R5: poisoned, obs nonfatal
    16'b1100_0100_0101_0010, // R6: response disabled, obs fatal
    16'b1001_0100_0001_0000, // R6: not posted, nothing routed
    16'b1101_1101_0001_1001, // R9: one-shot drop, nonfatal
    16'b1101_0100_0001_1000, // R4: drop, nothing routed
    16'b1101_0101_0001_1001  // R11: drop nonfatal route
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clear_all();
    perr_in = 0; clr_wr = 1; clr_mask = 2'b11;
    step();
    clr_wr = 0; clr_mask = 2'b00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    perr_in = 1; own_drv = 1; posted_op = 1; resp_en = 1;
    obs_flood_en = 1; obs_fatal_en = 1; obs_nonfatal_en = 1;
    step();
    // R1: reset holds everything low
    chk("R1 obs", stat_obs, 0);
    chk("R1 drop", stat_drop, 0);
    chk("R1 flood", flood_req, 0);
    chk("R1 fatal", fatal_req, 0);
    chk("R1 nonfatal", nonfatal_req, 0);
    perr_in = 0;
    rst_n = 1;
    step();

    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      {own_drv, posted_op, poisoned, resp_en, one_shot, drop_flood_inh,
       drop_fatal_en, drop_nonfatal_en, obs_flood_en, obs_fatal_en,
       obs_nonfatal_en} = v[15:5];
      clear_all();
      perr_in = 1;
      step();
      chk("R2 vec obs", stat_obs, v[4]);
      chk("R4 R5 R6 vec drop", stat_drop, v[3]);
      chk("R10 vec flood", flood_req, v[2]);
      chk("R11 vec fatal", fatal_req, v[1]);
      chk("R11 vec nonfatal", nonfatal_req, v[0]);
      perr_in = 0;
      step();
      chk("R2 vec obs held", stat_obs, v[4]);
      chk("R9 vec drop after", stat_drop, v[3] & ~v[11]);
    end

    // R3: long assertion with a clear in the middle
    one_shot = 0; own_drv = 1; posted_op = 1; poisoned = 0; resp_en = 1;
    clear_all();
    perr_in = 1;
    step();
    chk("R3 first log", stat_obs, 1);
    clr_wr = 1; clr_mask = 2'b01;
    step();
    clr_wr = 0; clr_mask = 2'b00;
    chk("R3 cleared", stat_obs, 0);
    step(); step();
    chk("R3 no relog while high", stat_obs, 0);
    perr_in = 0;
    step();
    perr_in = 1;
    step();
    chk("R3 relog on new edge", stat_obs, 1);
    perr_in = 0;
    step();

    // R7: mask positions and the strobe
    chk("R7 setup drop", stat_drop, 1);
    clr_mask = 2'b11;
    step();
    chk("R7 mask without strobe obs", stat_obs, 1);
    chk("R7 mask without strobe drop", stat_drop, 1);
    clr_wr = 1; clr_mask = 2'b01;
    step();
    chk("R7 bit0 clears obs", stat_obs, 0);
    chk("R7 bit0 keeps drop", stat_drop, 1);
    clr_mask = 2'b10;
    step();
    clr_wr = 0; clr_mask = 2'b00;
    chk("R7 bit1 clears drop", stat_drop, 0);

    // R8: event and clear in the same cycle
    perr_in = 1; clr_wr = 1; clr_mask = 2'b11;
    step();
    clr_wr = 0; clr_mask = 2'b00;
    chk("R8 obs set wins", stat_obs, 1);
    chk("R8 drop set wins", stat_drop, 1);
    perr_in = 0;
    step();

    // R9: one-shot while the indication stays high
    clear_all();
    one_shot = 1;
    perr_in = 1;
    step();
    chk("R9 pulse high", stat_drop, 1);
    step();
    chk("R9 pulse gone", stat_drop, 0);
    step();
    chk("R9 stays low", stat_drop, 0);
    chk("R9 obs still sticky", stat_obs, 1);
    perr_in = 0;
    step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule